// File: doc/BRIEF.md
# Pulse-Width Coded Byte Transmitter

This block sends one byte as a burst of eight back-to-back PWM periods on a single output line. Every period in a burst has the same length. The high time of each period carries one bit: a programmable short high time stands for a 0 and a programmable longer one stands for a 1. A byte is offered on a valid/ready handshake together with the period length and the two high-time values. All four values are captured when the byte is accepted. The block raises `busy` for the length of the burst and pulses `done` once when the burst ends.

Inside the block there is a 16-bit period counter that returns to zero at a programmed limit. A duty register is reloaded at each of those return points, and a shift register supplies the next bit. The duty register takes the duty of the first bit in the same clock that accepts the byte. The first period therefore starts at once with the right high time and is never dropped.

Top module: `pwbyte_tx`

## Requirements
- R1: While idle (`busy` low), `pwm_out` is low, `done` is low and `in_ready` is high. This is also the state after reset.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both high. `busy` is high from the next cycle on. While `busy` is high, `in_ready` stays low and `in_valid` with any `in_data` has no effect on the burst in progress.
- R3: An accepted byte produces exactly eight periods, so `busy` stays high for exactly 8*(`period_len`+1) cycles.
- R4: Each period lasts `period_len`+1 clock cycles. The counter runs from 0 to `period_len` and then reloads to 0.
- R5: In each period `pwm_out` is high for the first D cycles and low for the rest. D is `duty0` for a 0 bit and `duty1` for a 1 bit. The intended use is `duty0` < `duty1` <= `period_len`+1. D = 0 gives a period with no high time, and D = `period_len`+1 gives a period that is high throughout.
- R6: Bits go out most significant first, with `in_data[7]` in the first period and `in_data[0]` in the eighth. For example, 0x04 is sent as 0,0,0,0,0,1,0,0.
- R7: The first period begins in the first cycle that `busy` is high. Its high time is already the one for `in_data[7]`, so bit 7 is never lost.
- R8: `done` is high for exactly one cycle, which is the cycle right after the eighth period. `busy` goes low in that same cycle.
- R9: `period_len`, `duty0` and `duty1` are sampled only at acceptance. Changing them during a burst has no effect on that burst.
- R10: A byte offered in the `done` cycle is accepted there. Its first period follows at once, with no idle cycle between the two bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can accept a byte (not busy) |
| period_len | input | 16 | Counter limit; period is period_len+1 cycles |
| duty0 | input | 16 | High time in cycles for a 0 bit |
| duty1 | input | 16 | High time in cycles for a 1 bit |
| pwm_out | output | 1 | Serial pulse-width coded waveform |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at end of burst |

## Verification
A wrong internal state shows up on `pwm_out` within one period. A counter that misses its reload stretches a period, and the high/low comparison then goes wrong at the next boundary. A shifter that is one position off swaps the high times of neighbouring bits, which is visible in the first period where those bits differ. A duty register that is not preloaded corrupts the very first period, which is why the bench compares every cycle of every period against a model built from the byte and the captured settings. A bit counter that is off by one moves the fall of `busy` and the `done` pulse a whole period early or late, and the bench checks both in the exact cycle they are due.

// File: rtl/pwbt_pkg.sv
package pwbt_pkg;

   // Order in which data bits leave the shifter
   typedef enum logic {
      ORDER_LSB_FIRST = 1'b0,
      ORDER_MSB_FIRST = 1'b1
   } bit_order_e;

   localparam int unsigned DEF_CNT_W  = 16;
   localparam int unsigned DEF_DATA_W = 8;

endpackage

// File: rtl/pwbt_period_ctr.sv
module pwbt_period_ctr #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   assign wrap = (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (start) begin
         cnt <= '0;
      end else if (run) begin
         if (wrap) cnt <= '0;
         else      cnt <= cnt + 1'b1;
      end
   end

   // Counter never passes the reload point of the period (R4)
   assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt <= limit);

   // After the reload point the next period starts from zero (R4)
   assert_reload_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && wrap && !start) |=> cnt == '0);

endmodule

// File: rtl/pwbt_bit_shifter.sv
module pwbt_bit_shifter
   import pwbt_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter bit_order_e  ORDER  = ORDER_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [DATA_W-1:0] data,
   output logic              first_bit,
   output logic              next_bit,
   output logic              last
);

   localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] load_rest;
   logic [DATA_W-1:0] sh_shifted;
   logic [IDX_W-1:0]  idx_q;

   generate
      if (ORDER == ORDER_MSB_FIRST) begin : g_msb
         assign first_bit  = data[DATA_W-1];
         assign next_bit   = sh_q[DATA_W-1];
         assign load_rest  = {data[DATA_W-2:0], 1'b0};
         assign sh_shifted = {sh_q[DATA_W-2:0], 1'b0};
      end else begin : g_lsb
         assign first_bit  = data[0];
         assign next_bit   = sh_q[0];
         assign load_rest  = {1'b0, data[DATA_W-1:1]};
         assign sh_shifted = {1'b0, sh_q[DATA_W-1:1]};
      end
   endgenerate

   assign last = (idx_q == IDX_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load) begin
         sh_q  <= load_rest;
         idx_q <= '0;
      end else if (advance) begin
         sh_q  <= sh_shifted;
         idx_q <= idx_q + 1'b1;
      end
   end

   // Bit position stays inside the byte (R3)
   assert_idx_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IDX_LAST);

   // No advance past the last bit (R3)
   assert_no_advance_past_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |-> !last);

endmodule

// File: rtl/pwbt_duty_reg.sv
module pwbt_duty_reg #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             sel_one,
   input  logic [CNT_W-1:0] dz,
   input  logic [CNT_W-1:0] d1,
   output logic [CNT_W-1:0] duty_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    duty_q <= '0;
      else if (load) duty_q <= sel_one ? d1 : dz;
   end

   // A load always takes one of the two offered values (R5)
   assert_duty_from_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (duty_q == $past(dz)) || (duty_q == $past(d1)));

endmodule

// File: rtl/pwbyte_tx.sv
module pwbyte_tx
   import pwbt_pkg::*;
#(
   parameter int unsigned CNT_W  = DEF_CNT_W,
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter bit_order_e  ORDER  = ORDER_MSB_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [CNT_W-1:0]  period_len,
   input  logic [CNT_W-1:0]  duty0,
   input  logic [CNT_W-1:0]  duty1,
   output logic              pwm_out,
   output logic              busy,
   output logic              done
);

   generate
      if (CNT_W < 2)  begin : g_bad_cnt  $error("CNT_W must be at least 2");  end
      if (DATA_W < 2) begin : g_bad_data $error("DATA_W must be at least 2"); end
   endgenerate

   logic [CNT_W-1:0] per_q, dz_q, d1_q;
   logic [CNT_W-1:0] cnt, duty_q;
   logic [CNT_W-1:0] dz_src, d1_src;
   logic             wrap, first_bit, next_bit, last;
   logic             accept, period_end, burst_end, step;

   assign in_ready   = !busy;
   assign accept     = in_valid && !busy;
   assign period_end = busy && wrap;
   assign burst_end  = period_end && last;
   assign step       = period_end && !last;

   // Settings captured with the byte
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= '0;
         dz_q  <= '0;
         d1_q  <= '0;
      end else if (accept) begin
         per_q <= period_len;
         dz_q  <= duty0;
         d1_q  <= duty1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= burst_end;
         if (accept)         busy <= 1'b1;
         else if (burst_end) busy <= 1'b0;
      end
   end

   pwbt_period_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept),
      .run   (busy),
      .limit (per_q),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   pwbt_bit_shifter #(.DATA_W(DATA_W), .ORDER(ORDER)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .advance   (step),
      .data      (in_data),
      .first_bit (first_bit),
      .next_bit  (next_bit),
      .last      (last)
   );

   // Preload at acceptance uses live inputs; later reloads use captured ones
   assign dz_src = accept ? duty0 : dz_q;
   assign d1_src = accept ? duty1 : d1_q;

   pwbt_duty_reg #(.CNT_W(CNT_W)) u_duty (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept || step),
      .sel_one (accept ? first_bit : next_bit),
      .dz      (dz_src),
      .d1      (d1_src),
      .duty_q  (duty_q)
   );

   assign pwm_out = busy && (cnt < duty_q);

   // Handshake starts the burst on the next cycle (R2)
   assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> busy);

   // Done is a single cycle and coincides with busy falling (R8)
   assert_done_with_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // Captured settings hold through a burst (R9)
   assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(per_q) && $stable(dz_q) && $stable(d1_q)));

   // Idle line stays low (R1)
   assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> (!pwm_out && !done));

endmodule

// File: tb/sim_pwbyte_tx.sv
`timescale 1ns/1ps
module sim_pwbyte_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [15:0] period_len = '0;
   logic [15:0] duty0 = '0;
   logic [15:0] duty1 = '0;
   logic        pwm_out, busy, done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pwbyte_tx u0 (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .period_len(period_len), .duty0(duty0),
      .duty1(duty1), .pwm_out(pwm_out), .busy(busy), .done(done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drives a byte at the current negedge; returns at the done-cycle negedge
   task automatic burst(input logic [7:0] data, input int p, input int dz, input int d1,
                        input bit perturb);
      int bad;
      period_len = 16'(p);
      duty0      = 16'(dz);
      duty1      = 16'(d1);
      in_data    = data;
      in_valid   = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R7 busy in first cycle", {31'b0, busy}, 32'd1);
      for (int b = 0; b < 8; b++) begin
         int d;
         d = data[7-b] ? d1 : dz;
         bad = 0;
         for (int c = 0; c <= p; c++) begin
            if (pwm_out !== (c < d)) bad++;
            if (busy !== 1'b1 || done !== 1'b0) bad++;
            if (perturb) begin
               if (in_ready !== 1'b0) bad++;
               in_valid   = (c != p || b != 7);
               in_data    = ~data;
               period_len = 16'(p + 3);
               duty0      = 16'(d1);
               duty1      = 16'(dz);
            end
            @(negedge clk);
         end
         check($sformatf("R3 R4 R5 R6 bit %0d period mismatches", 7 - b), bad, 0);
      end
      if (perturb) begin
         in_valid   = 1'b0;
         period_len = 16'(p);
         duty0      = 16'(dz);
         duty1      = 16'(d1);
      end
      check("R8 done after eighth period", {31'b0, done}, 32'd1);
      check("R3 busy low after eight periods", {31'b0, busy}, 32'd0);
   endtask

   task automatic finish_idle();
      @(negedge clk);
      check("R8 done single cycle", {31'b0, done}, 32'd0);
      check("R1 idle output low", {31'b0, pwm_out}, 32'd0);
      check("R1 ready when idle", {31'b0, in_ready}, 32'd1);
   endtask

   task automatic t_reset();
      check("R1 reset busy", {31'b0, busy}, 32'd0);
      check("R1 reset done", {31'b0, done}, 32'd0);
      check("R1 reset pwm", {31'b0, pwm_out}, 32'd0);
      check("R1 reset ready", {31'b0, in_ready}, 32'd1);
   endtask

   task automatic t_basic();
      burst(8'h04, 9, 3, 7, 0);  finish_idle();
      burst(8'hA5, 4, 1, 3, 0);  finish_idle();
   endtask

   task automatic t_order();
      burst(8'h80, 5, 2, 4, 0);  finish_idle();
      burst(8'h01, 5, 2, 4, 0);  finish_idle();
   endtask

   task automatic t_extremes();
      burst(8'h3C, 3, 0, 4, 0);  finish_idle();
   endtask

   task automatic t_ignore_busy();
      burst(8'h96, 6, 2, 5, 1);  finish_idle();
   endtask

   task automatic t_back_to_back();
      burst(8'hC3, 4, 1, 3, 0);
      burst(8'h5A, 4, 1, 3, 0);  // R10 offered in done cycle
      finish_idle();
   endtask

   task automatic t_idle_ignore();
      // Nothing offered: output stays low for a while (R1)
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
         if (pwm_out !== 1'b0 || busy !== 1'b0) bad++;
         @(negedge clk);
      end
      check("R1 idle stays low", bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_order();
      t_extremes();
      t_ignore_busy();
      t_back_to_back();
      t_idle_ignore();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule